// File: doc/BRIEF.md
# Stream-to-Burst DMA Source with Early Termination

This block is the source end of a DMA engine. Software-side logic hands it segment descriptors, one per fixed-size burst, and each descriptor says whether it is the final segment of its transfer. For each descriptor the block opens its stream input and takes up to `BURST_LEN` beats. It passes every beat straight through to a destination stage. When the burst closes, it issues one burst descriptor that carries the burst ID, the number of beats actually received, and an end-of-transfer flag.

A stream can end a transfer before the programmed length by raising TLAST. If that happens in a burst that is not the transfer's final segment, the block does four things. It pulses a rewind request whose ID is the one the next real burst will carry. It stops taking stream data. It accepts and discards the remaining segment descriptors up to and including the one marked last, and emits one completion pulse for each descriptor it discards. Any transfer cut short by TLAST has its received beat count pushed into a four-entry queue that software can read. A control input gates this reporting, and a sticky flag records pushes that were lost because the queue was full. A debug output shows the beats moved in the current transfer.

Top module: `stream_burst_src`

## Requirements
- R1: One cycle after a burst's final beat, `bd_valid_o` pulses with `bd_beats_o` equal to the beats actually taken in that burst (`BURST_LEN` for a full burst, fewer when TLAST cut it). `bd_id_o` starts at 0 after reset and increases by one per burst, wrapping at 2^`ID_W`.
- R2: TLAST in a burst whose segment is not marked last is an early abort. In the same cycle as that burst's descriptor, `rewind_o` pulses and `rewind_id_o` equals that burst's ID plus one.
- R3: After an early abort, `s_ready_o` stays low. Segment descriptors are accepted and discarded, and no burst descriptor is issued, until a descriptor with `seg_last_i`=1 has been accepted. The block then returns to idle.
- R4: `cpl_valid_o` pulses once, one cycle after each discarded descriptor is accepted.
- R5: A transfer is partial when TLAST arrives anywhere except on the final beat of a full last segment. When reporting is enabled, its total received beat count is pushed into the queue. `plq_nonempty_o` is high while the queue holds an entry. `plq_data_o` shows the oldest entry, and `plq_pop_i` removes it.
- R6: With `report_en_i` low, partial transfers push nothing.
- R7: The queue holds 4 entries. A push while it is full is dropped and sets `plq_ovf_o`, which stays set until reset. Fullness is judged before a pop in the same cycle, so a push that coincides with a pop on a full queue is still dropped.
- R8: `s_ready_o` is high only while a segment descriptor is being served. With no descriptor, a stream beat is neither taken nor forwarded.
- R9: `dbg_beats_o` counts the beats taken in the current transfer, holds that count after the transfer ends, and clears when the next transfer's first descriptor is accepted.
- R10: `d_valid_o`/`d_data_o` mirror each accepted stream beat in the same cycle. `d_last_o` marks each burst's final beat. `d_eot_o` marks the final beat of the last programmed burst or of the burst TLAST cut short.
- R11: After reset, `seg_ready_o`=1, `s_ready_o`=0, and all pulses, the queue status, the overflow flag and `dbg_beats_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_valid_i | input | 1 | Segment descriptor offered |
| seg_last_i | input | 1 | Offered segment is the last of its transfer |
| seg_ready_o | output | 1 | Segment descriptor accepted this cycle when valid |
| s_valid_i | input | 1 | Stream beat valid |
| s_data_i | input | DATA_W | Stream beat data |
| s_last_i | input | 1 | Stream TLAST |
| s_ready_o | output | 1 | Stream beat accepted when valid |
| d_valid_o | output | 1 | Beat forwarded to destination |
| d_data_o | output | DATA_W | Forwarded beat data |
| d_last_o | output | 1 | Final beat of a burst |
| d_eot_o | output | 1 | Final beat of the transfer |
| bd_valid_o | output | 1 | Burst descriptor pulse |
| bd_beats_o | output | $clog2(BURST_LEN+1) | Beats received in the burst |
| bd_id_o | output | ID_W | Burst ID |
| bd_eot_o | output | 1 | Burst ends the transfer |
| rewind_o | output | 1 | Burst ID rewind request |
| rewind_id_o | output | ID_W | ID of the next real burst |
| cpl_valid_o | output | 1 | Completion for a discarded segment |
| report_en_i | input | 1 | Enable partial-length reporting |
| plq_pop_i | input | 1 | Remove the oldest queue entry |
| plq_data_o | output | LEN_W | Oldest partial length |
| plq_nonempty_o | output | 1 | Queue holds an entry |
| plq_ovf_o | output | 1 | Sticky: a partial length was dropped |
| dbg_beats_o | output | LEN_W | Beats taken in the current transfer |

## Verification
Two functions can fall in the same cycle. A partial-length push happens on the edge that takes a cut-short final beat, and software can pop the queue on that same edge. The bench provokes this by filling the queue with five short transfers, then running a sixth whose final beat carries `plq_pop_i`. It judges the outcome against a bench-side model that drops the push because the queue was full before the pop, keeps the overflow flag set, and leaves three entries. A second coincidence is TLAST on the last planned beat of a non-last segment. This is a full-length burst that is still an abort, and the full sweep of every cut position across one to three segments checks the rewind, the discards and the reported length for it.

// File: rtl/dmasrc_pkg.sv
package dmasrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_DROP  = 2'd2
  } src_state_e;
endpackage

// File: rtl/dmasrc_plq.sv
module dmasrc_plq #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         nonempty_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push, do_pop;

  assign full       = (count == CNT_MAX);
  assign do_push    = push_i & ~full;
  assign do_pop     = pop_i & (count != '0);
  assign nonempty_o = (count != '0);
  assign dout_o     = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (!do_push && do_pop) count <= count - 1'b1;
      if (push_i && full) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dmasrc_ctrl.sv
module dmasrc_ctrl
  import dmasrc_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 12,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg_valid_i,
  input  logic             seg_last_i,
  output logic             seg_ready_o,
  input  logic             s_valid_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  output logic             beat_o,
  output logic             burst_end_o,
  output logic             eot_beat_o,
  output logic             partial_o,
  output logic [LEN_W-1:0] partial_len_o,
  output logic             bd_valid_o,
  output logic [CNT_W-1:0] bd_beats_o,
  output logic [ID_W-1:0]  bd_id_o,
  output logic             bd_eot_o,
  output logic             rewind_o,
  output logic [ID_W-1:0]  rewind_id_o,
  output logic             cpl_valid_o,
  output logic [LEN_W-1:0] dbg_beats_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST_LEN - 1);

  src_state_e       state;
  logic             seg_last_q, fresh;
  logic [CNT_W-1:0] cnt;
  logic [ID_W-1:0]  burst_id;
  logic [LEN_W-1:0] total;
  logic             seg_fire, full_beat, abort;

  assign s_ready_o     = (state == ST_BURST);
  assign seg_ready_o   = (state != ST_BURST);
  assign seg_fire      = seg_valid_i & seg_ready_o;
  assign beat_o        = s_valid_i & s_ready_o;
  assign full_beat     = (cnt == LAST_CNT);
  assign burst_end_o   = beat_o & (full_beat | s_last_i);
  assign eot_beat_o    = burst_end_o & (seg_last_q | s_last_i);
  assign abort         = burst_end_o & s_last_i & ~seg_last_q;
  // any TLAST except on the programmed final beat shortens the transfer
  assign partial_o     = burst_end_o & s_last_i & ~(seg_last_q & full_beat);
  assign partial_len_o = total + 1'b1;
  assign dbg_beats_o   = total;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      seg_last_q  <= 1'b0;
      fresh       <= 1'b1;
      cnt         <= '0;
      burst_id    <= '0;
      total       <= '0;
      bd_valid_o  <= 1'b0;
      bd_beats_o  <= '0;
      bd_id_o     <= '0;
      bd_eot_o    <= 1'b0;
      rewind_o    <= 1'b0;
      rewind_id_o <= '0;
      cpl_valid_o <= 1'b0;
    end else begin
      bd_valid_o  <= 1'b0;
      rewind_o    <= 1'b0;
      cpl_valid_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (seg_fire) begin
          seg_last_q <= seg_last_i;
          cnt        <= '0;
          state      <= ST_BURST;
          if (fresh) begin
            total <= '0;
            fresh <= 1'b0;
          end
        end
        ST_BURST: if (beat_o) begin
          cnt   <= cnt + 1'b1;
          total <= total + 1'b1;
          if (burst_end_o) begin
            bd_valid_o <= 1'b1;
            bd_beats_o <= cnt + 1'b1;
            bd_id_o    <= burst_id;
            bd_eot_o   <= eot_beat_o;
            burst_id   <= burst_id + 1'b1;
            if (eot_beat_o) fresh <= 1'b1;
            if (abort) begin
              rewind_o    <= 1'b1;
              rewind_id_o <= burst_id + 1'b1;
              state       <= ST_DROP;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_DROP: if (seg_fire) begin
          cpl_valid_o <= 1'b1;
          if (seg_last_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_burst_src.sv
module stream_burst_src #(
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 12,
  parameter int PLQ_DEPTH = 4,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_valid_i,
  input  logic              seg_last_i,
  output logic              seg_ready_o,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              d_valid_o,
  output logic [DATA_W-1:0] d_data_o,
  output logic              d_last_o,
  output logic              d_eot_o,
  output logic              bd_valid_o,
  output logic [CNT_W-1:0]  bd_beats_o,
  output logic [ID_W-1:0]   bd_id_o,
  output logic              bd_eot_o,
  output logic              rewind_o,
  output logic [ID_W-1:0]   rewind_id_o,
  output logic              cpl_valid_o,
  input  logic              report_en_i,
  input  logic              plq_pop_i,
  output logic [LEN_W-1:0]  plq_data_o,
  output logic              plq_nonempty_o,
  output logic              plq_ovf_o,
  output logic [LEN_W-1:0]  dbg_beats_o
);
  logic             partial;
  logic [LEN_W-1:0] partial_len;

  dmasrc_ctrl #(.BURST_LEN(BURST_LEN), .ID_W(ID_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .seg_valid_i, .seg_last_i, .seg_ready_o,
    .s_valid_i, .s_last_i, .s_ready_o,
    .beat_o        (d_valid_o),
    .burst_end_o   (d_last_o),
    .eot_beat_o    (d_eot_o),
    .partial_o     (partial),
    .partial_len_o (partial_len),
    .bd_valid_o, .bd_beats_o, .bd_id_o, .bd_eot_o,
    .rewind_o, .rewind_id_o, .cpl_valid_o, .dbg_beats_o
  );

  assign d_data_o = s_data_i;

  dmasrc_plq #(.DEPTH(PLQ_DEPTH), .W(LEN_W)) u_plq (
    .clk_i, .rst_ni,
    .push_i     (partial & report_en_i),
    .din_i      (partial_len),
    .pop_i      (plq_pop_i),
    .dout_o     (plq_data_o),
    .nonempty_o (plq_nonempty_o),
    .ovf_o      (plq_ovf_o)
  );
endmodule

// File: rtl/stream_burst_src_chk.sv
module stream_burst_src_chk #(
  parameter int BURST_LEN = 4,
  parameter int ID_W      = 4,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seg_valid_i,
  input logic             seg_ready_o,
  input logic             s_ready_o,
  input logic             d_valid_o,
  input logic             d_last_o,
  input logic             d_eot_o,
  input logic             bd_valid_o,
  input logic [CNT_W-1:0] bd_beats_o,
  input logic [ID_W-1:0]  bd_id_o,
  input logic             bd_eot_o,
  input logic             rewind_o,
  input logic [ID_W-1:0]  rewind_id_o,
  input logic             cpl_valid_o,
  input logic             plq_ovf_o
);
  assert_beats_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bd_valid_o |-> (bd_beats_o != '0 && bd_beats_o <= CNT_W'(BURST_LEN)));
  assert_short_ends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bd_valid_o && bd_beats_o != CNT_W'(BURST_LEN)) |-> bd_eot_o);
  assert_rewind_id_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_o |-> (bd_valid_o && bd_eot_o && rewind_id_o == ID_W'(bd_id_o + 1'b1)));
  assert_drop_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_o |-> (!s_ready_o && seg_ready_o));
  assert_cpl_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> $past(seg_valid_i && seg_ready_o));
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(plq_ovf_o) |-> plq_ovf_o);
  assert_no_idle_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_ready_o |-> !d_valid_o);
  assert_eot_on_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_eot_o |-> (d_last_o && d_valid_o));
endmodule

bind stream_burst_src stream_burst_src_chk #(.BURST_LEN(BURST_LEN), .ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .seg_valid_i(seg_valid_i), .seg_ready_o(seg_ready_o),
  .s_ready_o(s_ready_o), .d_valid_o(d_valid_o), .d_last_o(d_last_o), .d_eot_o(d_eot_o),
  .bd_valid_o(bd_valid_o), .bd_beats_o(bd_beats_o), .bd_id_o(bd_id_o), .bd_eot_o(bd_eot_o),
  .rewind_o(rewind_o), .rewind_id_o(rewind_id_o), .cpl_valid_o(cpl_valid_o),
  .plq_ovf_o(plq_ovf_o)
);

// File: tb/stream_burst_src_test.sv
`timescale 1ns/1ps
module stream_burst_src_test;
  localparam int DW = 16, BL = 4, IW = 4, LW = 12;
  localparam int CW = $clog2(BL + 1);

  logic clk = 0, rst_n = 0;
  logic seg_valid = 0, seg_last = 0, seg_ready;
  logic s_valid = 0, s_last = 0, s_ready;
  logic [DW-1:0] s_data = '0, d_data;
  logic d_valid, d_last, d_eot, bd_valid, bd_eot, rewind, cpl_valid;
  logic [CW-1:0] bd_beats;
  logic [IW-1:0] bd_id, rewind_id;
  logic report_en = 1, plq_pop = 0, plq_nonempty, plq_ovf;
  logic [LW-1:0] plq_data, dbg_beats;

  int checks = 0, errors = 0, exp_id = 0;
  int mq[$];
  bit exp_ovf = 0;

  always #2.5 clk = ~clk;

  stream_burst_src #(.DATA_W(DW), .BURST_LEN(BL), .ID_W(IW), .LEN_W(LW), .PLQ_DEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_valid_i(seg_valid), .seg_last_i(seg_last), .seg_ready_o(seg_ready),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
    .d_valid_o(d_valid), .d_data_o(d_data), .d_last_o(d_last), .d_eot_o(d_eot),
    .bd_valid_o(bd_valid), .bd_beats_o(bd_beats), .bd_id_o(bd_id), .bd_eot_o(bd_eot),
    .rewind_o(rewind), .rewind_id_o(rewind_id), .cpl_valid_o(cpl_valid),
    .report_en_i(report_en), .plq_pop_i(plq_pop), .plq_data_o(plq_data),
    .plq_nonempty_o(plq_nonempty), .plq_ovf_o(plq_ovf), .dbg_beats_o(dbg_beats)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one transfer of nseg segments, TLAST on global beat cut (0 = none)
  task automatic run_xfer(input int nseg, input int cut, input bit pop_end);
    int tot  = nseg * BL;
    int act  = (cut > 0) ? cut : tot;
    int nb   = (act + BL - 1) / BL;
    bit part = (cut > 0) && (cut < tot);
    bit abrt = (cut > 0) && (nb < nseg || (nb == nseg && 0));
    int g    = 0;
    abrt = (cut > 0) && ((cut - 1) / BL < nseg - 1);
    for (int k = 0; k < nb; k++) begin
      int bl = (act - k * BL < BL) ? act - k * BL : BL;
      seg_valid = 1;
      seg_last  = (k == nseg - 1);
      chk(seg_ready == 1, "R8 seg_ready", seg_ready, 1);
      step();
      seg_valid = 0;
      for (int b = 0; b < bl; b++) begin
        g++;
        s_valid = 1;
        s_data  = DW'(g * 37 + nseg);
        s_last  = (g == cut);
        if (b == bl - 1 && pop_end) plq_pop = 1;
        #1;
        chk(s_ready == 1 && d_valid == 1, "R10 d_valid", d_valid, 1);
        chk(d_data == s_data, "R10 d_data", d_data, s_data);
        chk(d_last == (b == bl - 1), "R10 d_last", d_last, b == bl - 1);
        chk(d_eot == (b == bl - 1 && k == nb - 1), "R10 d_eot", d_eot, b == bl - 1 && k == nb - 1);
        step();
      end
      s_valid = 0;
      s_last  = 0;
      if (pop_end && k == nb - 1) begin
        int s = mq.size();
        plq_pop = 0;
        if (part && report_en) begin
          if (s < 4) mq.push_back(act); else exp_ovf = 1;
        end
        if (s > 0) void'(mq.pop_front());
      end else if (part && report_en && k == nb - 1) begin
        if (mq.size() < 4) mq.push_back(act); else exp_ovf = 1;
      end
      chk(bd_valid == 1, "R1 bd_valid", bd_valid, 1);
      chk(bd_beats == CW'(bl), "R1 bd_beats", bd_beats, bl);
      chk(bd_id == IW'(exp_id), "R1 bd_id", bd_id, IW'(exp_id));
      chk(bd_eot == (k == nb - 1), "R10 bd_eot", bd_eot, k == nb - 1);
      chk(rewind == (abrt && k == nb - 1), "R2 rewind", rewind, abrt && k == nb - 1);
      if (abrt && k == nb - 1)
        chk(rewind_id == IW'(exp_id + 1), "R2 rewind_id", rewind_id, IW'(exp_id + 1));
      exp_id++;
    end
    if (abrt) begin
      for (int k = nb; k < nseg; k++) begin
        seg_valid = 1;
        seg_last  = (k == nseg - 1);
        s_valid   = 1;
        #1;
        chk(s_ready == 0 && seg_ready == 1, "R3 drop stall", s_ready, 0);
        step();
        seg_valid = 0;
        s_valid   = 0;
        chk(cpl_valid == 1, "R4 cpl_valid", cpl_valid, 1);
        chk(bd_valid == 0, "R3 bd held", bd_valid, 0);
      end
      chk(seg_ready == 1 && s_ready == 0, "R3 back to idle", s_ready, 0);
    end
    step();
    chk(cpl_valid == 0, "R4 single pulse", cpl_valid, 0);
    chk(dbg_beats == LW'(act), "R9 dbg_beats", dbg_beats, act);
    chk(plq_nonempty == (mq.size() > 0), "R5 nonempty", plq_nonempty, mq.size() > 0);
    chk(plq_ovf == exp_ovf, "R7 ovf", plq_ovf, exp_ovf);
  endtask

  task automatic drain();
    while (mq.size() > 0) begin
      chk(plq_nonempty == 1, "R5 nonempty", plq_nonempty, 1);
      chk(plq_data == LW'(mq[0]), "R5 plq_data", plq_data, mq[0]);
      plq_pop = 1;
      step();
      plq_pop = 0;
      void'(mq.pop_front());
    end
    chk(plq_nonempty == 0, "R5 empty", plq_nonempty, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(seg_ready == 1, "R11 seg_ready", seg_ready, 1);
    chk(s_ready == 0, "R11 s_ready", s_ready, 0);
    chk(bd_valid == 0 && rewind == 0 && cpl_valid == 0, "R11 pulses", bd_valid, 0);
    chk(plq_nonempty == 0 && plq_ovf == 0, "R11 queue", plq_nonempty, 0);
    chk(dbg_beats == 0, "R11 dbg", dbg_beats, 0);

    // R8: stream offered with no descriptor
    s_valid = 1;
    s_data  = 16'hBEEF;
    #1;
    chk(s_ready == 0 && d_valid == 0, "R8 idle no take", d_valid, 0);
    step();
    s_valid = 0;
    chk(bd_valid == 0 && dbg_beats == 0, "R8 nothing moved", dbg_beats, 0);

    // sweep: segment count x TLAST position
    for (int n = 1; n <= 3; n++)
      for (int c = 0; c <= n * BL; c++) begin
        run_xfer(n, c, 0);
        drain();
      end

    // R6: reporting disabled
    report_en = 0;
    run_xfer(2, 3, 0);
    chk(plq_nonempty == 0, "R6 no push", plq_nonempty, 0);
    run_xfer(3, 6, 0);
    chk(plq_nonempty == 0, "R6 no push", plq_nonempty, 0);
    report_en = 1;

    // R7: overflow, then push colliding with pop on a full queue
    for (int i = 1; i <= 5; i++) run_xfer(2, i, 0);
    chk(plq_ovf == 1, "R7 ovf set", plq_ovf, 1);
    chk(mq.size() == 4, "R7 depth", mq.size(), 4);
    run_xfer(1, 2, 1);
    chk(mq.size() == 3, "R7 push dropped on pop", mq.size(), 3);
    drain();
    run_xfer(1, 0, 0);
    chk(plq_ovf == 1, "R7 sticky", plq_ovf, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule